// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block connects an 8-bit host bus to four separate register banks. Each bank belongs to one framer. Two strap inputs set how the bus pins are used. The bus-mode strap selects between a separate address bus and a multiplexed address/data bus. The bus-type strap selects the strobe style: either a read strobe and a write strobe, or a data strobe with a read/write direction line. An active-low chip select gates every access. A 2-bit bank select picks the bank that the access reaches.

Each write strobe produces one single-cycle write pulse on the selected bank. The pulse carries the address and the write data. Reads come back through a multiplexer that takes the selected bank's read data. The block also answers two kinds of address itself. Address 0x0F holds a read-only ID byte. The upper address range is hidden. The strobes and the chip select are asynchronous, so each passes through two flip-flops before it is used. An open-drain interrupt request is modelled as a drive-low enable. It is active whenever any bank asks for service.

Top module: `host_reg_port`

## Requirements
- R1: With `mux_mode` low, the access address is `adr[7:0]` taken straight from the address pins (bit 6 is the dual-use pin), and `d_in` carries only data.
- R2: With `mux_mode` high, the address is latched from `d_in` on the rising edge of `adr[6]` (latch strobe). Address pins `adr[7]` and `adr[5:0]` have no effect on which register is reached.
- R3: With `bus_type` low, `rd_ds` is an active-low read strobe and `wr_rw` is an active-low write strobe.
- R4: With `bus_type` high, `rd_ds` is a data strobe and `wr_rw` gives the direction (1 = read, 0 = write). The data strobe is active low when `mux_mode` is low and active high when `mux_mode` is high.
- R5: While `cs_n` is high, strobes produce no write pulse and no bus drive.
- R6: Each write strobe assertion produces exactly one single-cycle pulse on `reg_wr`. Only the bit that `bank_sel` picks is set (bit i = bank i).
- R7: Address 0x0F of every bank reads {1'b0, ID_HI, REV}, which is 0x23 by default. Writes to it produce no pulse.
- R8: Addresses whose upper nibble is 0xA to 0xF produce no write pulse and read 0x00.
- R9: `d_oe` is high only while a read strobe is active with chip select asserted. Otherwise it is low, including after reset.
- R10: `irq_drive_low` is high whenever any bit of `irq_req` is high, and low otherwise.
- R11: A read of any other address returns the selected bank's byte from `bank_rdata` (bank i at bits 8i+7:8i).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mux_mode | input | 1 | Strap: 0 separate address bus, 1 multiplexed bus |
| bus_type | input | 1 | Strap: 0 read/write strobes, 1 data strobe plus direction |
| cs_n | input | 1 | Active-low chip select |
| bank_sel | input | 2 | Bank (framer) select |
| adr | input | 8 | Address pins. Bit 6 doubles as the address latch strobe |
| rd_ds | input | 1 | Read strobe or data strobe |
| wr_rw | input | 1 | Write strobe or read/write direction |
| d_in | input | 8 | Data bus input (address/data when multiplexed) |
| d_out | output | 8 | Read data |
| d_oe | output | 1 | Data bus output enable |
| reg_addr | output | 8 | Register address presented to the banks |
| reg_wdata | output | 8 | Write data presented to the banks |
| reg_wr | output | 4 | Per-bank single-cycle write pulse |
| bank_rdata | input | 32 | Read data from all four banks |
| irq_req | input | 4 | Per-bank service request |
| irq_drive_low | output | 1 | Enable to pull the open-drain interrupt line low |

## Verification
Assertions check four things on every cycle. A write pulse reaches at most one bank and lasts one cycle. No pulse ever reaches the ID address or the hidden range. Any bus drive is preceded by an asserted chip select, and a driven read of a hidden address shows zero. The bench scenarios cover the rest. They show that each strap combination decodes strobes and addresses correctly, and that multiplexed mode ignores the dedicated address pins. They show that written bytes come back from the same bank and no other. They also check the ID value, the interrupt request and the effect of a deselected chip.

// File: rtl/host_reg_port.sv
module host_reg_port #(
  parameter int NBANK = 4,
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] ID_ADDR = 8'h0F,
  parameter logic [2:0] ID_HI = 3'b010,
  parameter logic [3:0] REV = 4'h3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mux_mode,
  input  logic                  bus_type,
  input  logic                  cs_n,
  input  logic [$clog2(NBANK)-1:0] bank_sel,
  input  logic [AW-1:0]         adr,
  input  logic                  rd_ds,
  input  logic                  wr_rw,
  input  logic [DW-1:0]         d_in,
  output logic [DW-1:0]         d_out,
  output logic                  d_oe,
  output logic [AW-1:0]         reg_addr,
  output logic [DW-1:0]         reg_wdata,
  output logic [NBANK-1:0]      reg_wr,
  input  logic [NBANK*DW-1:0]   bank_rdata,
  input  logic [NBANK-1:0]      irq_req,
  output logic                  irq_drive_low
);
  localparam int BW = $clog2(NBANK);
  localparam logic [DW-1:0] ID_VAL = {1'b0, ID_HI, REV};

  logic [3:0] s1, s2;
  logic prev_w, prev_ale;
  logic [AW-1:0] lat_addr;

  wire ale_s = s2[3];
  wire rw_s  = s2[2];
  wire rd_s  = s2[1];
  wire cs_s  = s2[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      prev_w <= 1'b0;
      prev_ale <= 1'b0;
      lat_addr <= '0;
    end else begin
      s1 <= {adr[6], wr_rw, rd_ds, ~cs_n};
      s2 <= s1;
      prev_w <= wr_act;
      prev_ale <= ale_s;
      if (mux_mode && ale_s && !prev_ale) lat_addr <= d_in[AW-1:0];
    end
  end

  logic ds_on, rd_act, wr_act, hidden, blocked, wr_go;
  assign ds_on   = mux_mode ? rd_s : ~rd_s;
  assign rd_act  = cs_s & (bus_type ? (ds_on & rw_s)  : ~rd_s);
  assign wr_act  = cs_s & (bus_type ? (ds_on & ~rw_s) : ~rw_s);
  assign reg_addr  = mux_mode ? lat_addr : adr;
  assign reg_wdata = d_in;
  assign hidden  = reg_addr[AW-1 -: 4] >= 4'hA;
  assign blocked = hidden || (reg_addr == ID_ADDR);
  assign wr_go   = wr_act & ~prev_w & ~blocked;

  for (genvar i = 0; i < NBANK; i++) begin : g_wr
    assign reg_wr[i] = wr_go && (bank_sel == BW'(i));
  end

  assign d_oe  = rd_act;
  assign d_out = hidden ? '0 :
                 (reg_addr == ID_ADDR) ? ID_VAL :
                 bank_rdata[bank_sel*DW +: DW];
  assign irq_drive_low = |irq_req;

  a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_wr));
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr != '0) |=> (reg_wr == '0));
  a_r7_id_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr != '0) |-> (reg_addr != ID_ADDR));
  a_r8_hidden_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr != '0) |-> (reg_addr[AW-1 -: 4] < 4'hA));
  a_r8_hidden_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (d_oe && reg_addr[AW-1 -: 4] >= 4'hA) |-> (d_out == '0));
  a_r5_cs_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(d_oe) |-> !$past(cs_n, 2));
endmodule

// File: tb/test_host_reg_port.sv
module test_host_reg_port;
  logic clk = 0;
  logic rst_n = 0;
  logic mux_mode = 0, bus_type = 0, cs_n = 1;
  logic [1:0] bank_sel = 0;
  logic [7:0] adr = 0, d_in = 0;
  logic rd_ds = 1, wr_rw = 1;
  logic [7:0] d_out, reg_addr, reg_wdata;
  logic d_oe, irq_drive_low;
  logic [3:0] reg_wr, irq_req = 0;
  logic [31:0] bank_rdata;

  logic [7:0] mem [0:1023];
  logic [7:0] ref_m [0:1023];
  int pulse_cnt = 0, last_bank = -1;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  host_reg_port i_host_reg_port (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .bus_type(bus_type),
    .cs_n(cs_n), .bank_sel(bank_sel), .adr(adr), .rd_ds(rd_ds), .wr_rw(wr_rw),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .bank_rdata(bank_rdata),
    .irq_req(irq_req), .irq_drive_low(irq_drive_low));

  assign bank_rdata = {mem[{2'd3, reg_addr}], mem[{2'd2, reg_addr}],
                       mem[{2'd1, reg_addr}], mem[{2'd0, reg_addr}]};

  always @(negedge clk) begin
    for (int b = 0; b < 4; b++)
      if (reg_wr[b]) begin
        mem[{b[1:0], reg_addr}] = reg_wdata;
        pulse_cnt++;
        last_bank = b;
      end
  end

  function automatic logic [7:0] exp_read(input logic [1:0] b, input logic [7:0] a);
    if (a == 8'h0F) return 8'h23;
    if (a[7:4] >= 4'hA) return 8'h00;
    return ref_m[{b, a}];
  endfunction

  function automatic string mtag();
    return $sformatf("%s/%s", mux_mode ? "R2" : "R1", bus_type ? "R4" : "R3");
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    cs_n = 1;
    wr_rw = 1;
    rd_ds = (bus_type && mux_mode) ? 1'b0 : 1'b1;
  endtask

  task automatic set_mode(input bit m, input bit b);
    @(negedge clk);
    mux_mode = m;
    bus_type = b;
    adr[6] = 0;
    go_idle();
    repeat (3) @(negedge clk);
  endtask

  task automatic access(input bit is_wr, input bit use_cs, input logic [1:0] b,
                        input logic [7:0] a, input logic [7:0] wd,
                        output logic [7:0] rv, output bit oe);
    @(negedge clk);
    bank_sel = b;
    if (mux_mode) begin
      adr = 8'($urandom);
      adr[6] = 0;
      d_in = a;
      @(negedge clk);
      adr[6] = 1;
      repeat (4) @(negedge clk);
      adr[6] = 0;
      repeat (2) @(negedge clk);
      adr = 8'($urandom);
      adr[6] = 0;
    end else adr = a;
    d_in = is_wr ? wd : 8'($urandom);
    cs_n = !use_cs;
    if (!bus_type) begin
      if (is_wr) wr_rw = 0; else rd_ds = 0;
    end else begin
      wr_rw = !is_wr;
      rd_ds = mux_mode;
    end
    repeat (4) @(negedge clk);
    rv = d_out;
    oe = d_oe;
    go_idle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input bit use_cs, input logic [1:0] b,
                          input logic [7:0] a, input logic [7:0] wd);
    logic [7:0] rv;
    bit oe;
    int p0, expn;
    bit blk;
    p0 = pulse_cnt;
    blk = (a == 8'h0F) || (a[7:4] >= 4'hA);
    expn = (use_cs && !blk) ? 1 : 0;
    access(1, use_cs, b, a, wd, rv, oe);
    if (!use_cs) chk("R5 write pulses with cs_n high", pulse_cnt - p0, 0);
    else if (a == 8'h0F) chk("R7 write pulses to ID address", pulse_cnt - p0, 0);
    else if (blk) chk("R8 write pulses to hidden address", pulse_cnt - p0, 0);
    else begin
      chk({"R6 write pulse count ", mtag()}, pulse_cnt - p0, expn);
      chk("R6 pulsed bank", last_bank, int'(b));
    end
    if (expn == 1) ref_m[{b, a}] = wd;
  endtask

  task automatic do_read(input bit use_cs, input logic [1:0] b, input logic [7:0] a);
    logic [7:0] rv;
    bit oe;
    access(0, use_cs, b, a, 8'h00, rv, oe);
    if (!use_cs) chk("R5 drive with cs_n high", oe, 0);
    else begin
      chk({"R9 drive during read ", mtag()}, oe, 1);
      if (a == 8'h0F) chk("R7 ID read", rv, exp_read(b, a));
      else if (a[7:4] >= 4'hA) chk("R8 hidden read", rv, 0);
      else chk({"R11 bank read ", mtag()}, rv, exp_read(b, a));
    end
    chk("R9 no drive when idle", d_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 1024; k++) begin mem[k] = 0; ref_m[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset d_oe", d_oe, 0);
    chk("R6 reset reg_wr", reg_wr, 0);
    chk("R10 reset irq", irq_drive_low, 0);

    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      do_write(1, 2'(m), 8'h30 + 8'(m), 8'hC0 + 8'(m));
      do_write(1, 2'(m+1), 8'h30 + 8'(m), 8'h50 + 8'(m));
      do_read(1, 2'(m), 8'h30 + 8'(m));
      do_read(1, 2'(m+1), 8'h30 + 8'(m));
      do_write(1, 2'(m), 8'h0F, 8'hFF);
      do_read(1, 2'(m), 8'h0F);
      do_write(1, 2'(m), 8'hA5, 8'h77);
      do_read(1, 2'(m), 8'hA5);
      do_write(1, 2'(m), 8'h9F, 8'h3C);
      do_read(1, 2'(m), 8'h9F);
      do_write(0, 2'(m), 8'h31, 8'h11);
      do_read(0, 2'(m), 8'h31);
      do_read(1, 2'(m), 8'h31);
    end

    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      irq_req = (k == 0) ? 4'h0 : 4'(1 << (k % 4));
      if (k == 5) irq_req = 4'hF;
      @(negedge clk);
      chk("R10 interrupt drive", irq_drive_low, int'(irq_req != 0));
    end
    irq_req = 0;

    for (int k = 0; k < 300; k++) begin
      logic [7:0] a;
      logic [1:0] b;
      if (k % 25 == 0) set_mode($urandom_range(0, 1), $urandom_range(0, 1));
      b = 2'($urandom);
      a = 8'($urandom_range(0, 8'h47));
      if ($urandom_range(0, 9) == 0) a = 8'($urandom_range(8'hA0, 8'hFF));
      if ($urandom_range(0, 1)) do_write($urandom_range(0, 9) != 0, b, a, 8'($urandom));
      else do_read($urandom_range(0, 9) != 0, b, a);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule